// File: doc/BRIEF.md
# Processor Status Register with Trace-Trap Control

This block holds the status word of a 16-bit processor core and produces the flags that condition later instructions. Compare operations update three relation flags from a source and a destination operand. Add and subtract results deliver their carry/borrow and signed overflow, which are recorded in two further flags. Enable and disable strobes move a local interrupt enable, and a global enable is changed only through the direct write port. A maskable-interrupt acceptance output is high only when both enables are set.

Single-step tracing pairs a trace bit with a pending bit. When an instruction retires with tracing on, the pending bit is set, and it drives the trace-trap request. Entering any trap or interrupt clears both the trace bit and the pending bit. As a result, each instruction raises one trap request at most. All state sits in registers that reset synchronously, and every output comes straight from a flop.

Top module: `psr_core`

## Requirements
- R1: After a synchronous reset the status word, `irq_accept` and `trace_req` are all zero.
- R2: When `cmp_valid` is high, bit 6 (equal) becomes 1 if `cmp_dst == cmp_src`, bit 2 (unsigned-less) becomes 1 if `cmp_dst < cmp_src` unsigned, and bit 7 (signed-less) becomes 1 if `cmp_dst < cmp_src` signed. Each of these bits becomes 0 otherwise. When `cmp_valid` is low, all three bits hold.
- R3: When `alu_valid` is high, bit 0 takes `alu_carry` and bit 5 takes `alu_ovf`. Otherwise both bits hold.
- R4: `ei_op` sets bit 9 (local enable) and `di_op` clears it. If both are high in the same cycle, the bit is cleared.
- R5: `irq_accept` is 1 exactly when bit 9 and bit 11 (global enable) of the status word are both 1, and it changes in the same cycle as those bits.
- R6: A `retire` while bit 1 (trace) is 1 sets bit 10 (pending), and `trace_req` always equals bit 10.
- R7: `trap_enter` clears bits 1 and 10 on the next edge. This takes precedence over a `retire` in the same cycle.
- R8: A `wr_en` loads `wr_data` with bits 3, 4, 8 and 15:12 forced to zero. It overrides every other event in the same cycle, and those bits read as zero at all times.
- R9: Bit 10 stays 0 through any number of retires while bit 1 is 0. Once set, bit 10 stays set through further retires until a trap entry or a write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | Compare result to be recorded this cycle |
| cmp_src | input | OPND_W | First (source) compare operand |
| cmp_dst | input | OPND_W | Second (destination) compare operand |
| alu_valid | input | 1 | Add/subtract result flags to be recorded |
| alu_carry | input | 1 | Carry or borrow out of the add/subtract |
| alu_ovf | input | 1 | Signed overflow of the add/subtract |
| ei_op | input | 1 | Enable-interrupts instruction strobe |
| di_op | input | 1 | Disable-interrupts instruction strobe |
| trap_enter | input | 1 | Entry to a trap or interrupt service |
| retire | input | 1 | An instruction completes |
| wr_en | input | 1 | Direct status-word write |
| wr_data | input | 16 | Value for the direct write |
| psr_q | output | 16 | Current status word |
| irq_accept | output | 1 | Maskable interrupts may be accepted |
| trace_req | output | 1 | Trace trap requested |

## Verification
The compare flags are exercised with four operand kinds:
- equal operands;
- operands that are ordered the same way signed and unsigned;
- a pair where only the unsigned order says "less";
- a pair where only the signed order says "less".

Together these show whether the signed and unsigned relations have been confused. Directed sequences then cover:
- simultaneous enable and disable strobes;
- a write that coincides with a trap entry;
- back-to-back retires under tracing;
- a trap entry that lands on a retire.

These cases tell the event priorities apart. A long stretch of random strobes and operands is compared cycle by cycle against a behavioural model, which catches interactions that no directed case covers.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int PSR_W   = 16;
  localparam int B_CARRY = 0;
  localparam int B_TRACE = 1;
  localparam int B_ULT   = 2;
  localparam int B_OVF   = 5;
  localparam int B_EQ    = 6;
  localparam int B_SLT   = 7;
  localparam int B_LIE   = 9;
  localparam int B_PEND  = 10;
  localparam int B_GIE   = 11;

  // Bits that hold state; every other position reads as zero.
  localparam logic [PSR_W-1:0] LIVE_MASK =
    (PSR_W'(1) << B_CARRY) | (PSR_W'(1) << B_TRACE) | (PSR_W'(1) << B_ULT) |
    (PSR_W'(1) << B_OVF)   | (PSR_W'(1) << B_EQ)    | (PSR_W'(1) << B_SLT) |
    (PSR_W'(1) << B_LIE)   | (PSR_W'(1) << B_PEND)  | (PSR_W'(1) << B_GIE);

  typedef struct packed {
    logic eq;
    logic ult;
    logic slt;
  } cmp_rel_t;
endpackage

// File: rtl/psr_cmp_unit.sv
module psr_cmp_unit
  import psr_pkg::*;
#(
  parameter int OPND_W       = 16,
  parameter bit CMP_SUBTRACT = 1'b1
) (
  input  logic [OPND_W-1:0] src,
  input  logic [OPND_W-1:0] dst,
  output cmp_rel_t          rel
);
  localparam int MSB = OPND_W - 1;

  generate
    if (CMP_SUBTRACT) begin : g_sub
      // One subtractor yields all three relations.
      logic [OPND_W:0] diff;
      logic            sgn_diff;
      always_comb begin
        diff     = {1'b0, dst} - {1'b0, src};
        sgn_diff = dst[MSB] ^ src[MSB];
        rel.eq   = (diff[MSB:0] == '0);
        rel.ult  = diff[OPND_W];
        rel.slt  = sgn_diff ? dst[MSB] : diff[MSB];
      end
    end else begin : g_direct
      always_comb begin
        rel.eq  = (dst == src);
        rel.ult = (dst < src);
        rel.slt = ($signed(dst) < $signed(src));
      end
    end
  endgenerate
endmodule

// File: rtl/psr_flag_next.sv
module psr_flag_next
  import psr_pkg::*;
(
  input  logic     cmp_valid,
  input  cmp_rel_t rel,
  input  logic     alu_valid,
  input  logic     alu_carry,
  input  logic     alu_ovf,
  input  logic     cur_eq,
  input  logic     cur_ult,
  input  logic     cur_slt,
  input  logic     cur_carry,
  input  logic     cur_ovf,
  output logic     nxt_eq,
  output logic     nxt_ult,
  output logic     nxt_slt,
  output logic     nxt_carry,
  output logic     nxt_ovf
);
  always_comb begin
    nxt_eq    = cmp_valid ? rel.eq  : cur_eq;
    nxt_ult   = cmp_valid ? rel.ult : cur_ult;
    nxt_slt   = cmp_valid ? rel.slt : cur_slt;
    nxt_carry = alu_valid ? alu_carry : cur_carry;
    nxt_ovf   = alu_valid ? alu_ovf   : cur_ovf;
  end
endmodule

// File: rtl/psr_trace_next.sv
module psr_trace_next (
  input  logic trap_enter,
  input  logic retire,
  input  logic cur_trace,
  input  logic cur_pend,
  output logic nxt_trace,
  output logic nxt_pend
);
  always_comb begin
    nxt_trace = cur_trace;
    nxt_pend  = cur_pend;
    if (trap_enter) begin
      nxt_trace = 1'b0;
      nxt_pend  = 1'b0;
    end else if (retire && cur_trace) begin
      nxt_pend = 1'b1;
    end
  end
endmodule

// File: rtl/psr_irq_next.sv
module psr_irq_next (
  input  logic ei_op,
  input  logic di_op,
  input  logic cur_lie,
  output logic nxt_lie
);
  always_comb begin
    if (di_op)      nxt_lie = 1'b0;
    else if (ei_op) nxt_lie = 1'b1;
    else            nxt_lie = cur_lie;
  end
endmodule

// File: rtl/psr_core.sv
module psr_core
  import psr_pkg::*;
#(
  parameter int OPND_W       = 16,
  parameter bit CMP_SUBTRACT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_valid,
  input  logic [OPND_W-1:0] cmp_src,
  input  logic [OPND_W-1:0] cmp_dst,
  input  logic              alu_valid,
  input  logic              alu_carry,
  input  logic              alu_ovf,
  input  logic              ei_op,
  input  logic              di_op,
  input  logic              trap_enter,
  input  logic              retire,
  input  logic              wr_en,
  input  logic [PSR_W-1:0]  wr_data,
  output logic [PSR_W-1:0]  psr_q,
  output logic              irq_accept,
  output logic              trace_req
);
  logic [PSR_W-1:0] psr_r;
  logic [PSR_W-1:0] evt_vec;
  logic [PSR_W-1:0] nxt_vec;
  logic             acc_r;
  cmp_rel_t         rel;
  logic n_eq, n_ult, n_slt, n_carry, n_ovf, n_trace, n_pend, n_lie;

  psr_cmp_unit #(.OPND_W(OPND_W), .CMP_SUBTRACT(CMP_SUBTRACT)) u_cmp (
    .src (cmp_src),
    .dst (cmp_dst),
    .rel (rel)
  );

  psr_flag_next u_flags (
    .cmp_valid (cmp_valid),
    .rel       (rel),
    .alu_valid (alu_valid),
    .alu_carry (alu_carry),
    .alu_ovf   (alu_ovf),
    .cur_eq    (psr_r[B_EQ]),
    .cur_ult   (psr_r[B_ULT]),
    .cur_slt   (psr_r[B_SLT]),
    .cur_carry (psr_r[B_CARRY]),
    .cur_ovf   (psr_r[B_OVF]),
    .nxt_eq    (n_eq),
    .nxt_ult   (n_ult),
    .nxt_slt   (n_slt),
    .nxt_carry (n_carry),
    .nxt_ovf   (n_ovf)
  );

  psr_trace_next u_trace (
    .trap_enter (trap_enter),
    .retire     (retire),
    .cur_trace  (psr_r[B_TRACE]),
    .cur_pend   (psr_r[B_PEND]),
    .nxt_trace  (n_trace),
    .nxt_pend   (n_pend)
  );

  psr_irq_next u_irq (
    .ei_op   (ei_op),
    .di_op   (di_op),
    .cur_lie (psr_r[B_LIE]),
    .nxt_lie (n_lie)
  );

  always_comb begin
    evt_vec          = '0;
    evt_vec[B_CARRY] = n_carry;
    evt_vec[B_TRACE] = n_trace;
    evt_vec[B_ULT]   = n_ult;
    evt_vec[B_OVF]   = n_ovf;
    evt_vec[B_EQ]    = n_eq;
    evt_vec[B_SLT]   = n_slt;
    evt_vec[B_LIE]   = n_lie;
    evt_vec[B_PEND]  = n_pend;
    evt_vec[B_GIE]   = psr_r[B_GIE];
    nxt_vec = wr_en ? (wr_data & LIVE_MASK) : evt_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      psr_r <= '0;
      acc_r <= 1'b0;
    end else begin
      psr_r <= nxt_vec;
      acc_r <= nxt_vec[B_LIE] & nxt_vec[B_GIE];
    end
  end

  assign psr_q      = psr_r;
  assign irq_accept = acc_r;
  assign trace_req  = psr_r[B_PEND];
endmodule

// File: rtl/psr_core_chk.sv
module psr_core_chk
  import psr_pkg::*;
#(
  parameter int OPND_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cmp_valid,
  input logic [OPND_W-1:0] cmp_src,
  input logic [OPND_W-1:0] cmp_dst,
  input logic              alu_valid,
  input logic              alu_carry,
  input logic              ei_op,
  input logic              di_op,
  input logic              trap_enter,
  input logic              retire,
  input logic              wr_en,
  input logic [PSR_W-1:0]  psr_q,
  input logic              irq_accept,
  input logic              trace_req
);
  AST_DEAD_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (psr_q & ~LIVE_MASK) == '0); // R8
  AST_ACCEPT_GATE: assert property (@(posedge clk) disable iff (rst)
    irq_accept == (psr_q[B_LIE] & psr_q[B_GIE])); // R5
  AST_TRAP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (trap_enter && !wr_en) |=> (!psr_q[B_TRACE] && !psr_q[B_PEND])); // R7
  AST_EI_SETS: assert property (@(posedge clk) disable iff (rst)
    (ei_op && !di_op && !wr_en) |=> psr_q[B_LIE]); // R4
  AST_DI_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (di_op && !wr_en) |=> !psr_q[B_LIE]); // R4
  AST_PEND_ON_RETIRE: assert property (@(posedge clk) disable iff (rst)
    (retire && psr_q[B_TRACE] && !trap_enter && !wr_en) |=> psr_q[B_PEND]); // R6
  AST_REQ_IS_PEND: assert property (@(posedge clk) disable iff (rst)
    trace_req == psr_q[B_PEND]); // R6
  AST_NO_SPURIOUS_PEND: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !psr_q[B_PEND] && !(retire && psr_q[B_TRACE])) |=> !psr_q[B_PEND]); // R9
  AST_CMP_EQUAL: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && !wr_en && cmp_src == cmp_dst) |=> (psr_q[B_EQ] && !psr_q[B_ULT] && !psr_q[B_SLT])); // R2
  AST_CARRY_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (alu_valid && !wr_en) |=> (psr_q[B_CARRY] == $past(alu_carry))); // R3
endmodule

bind psr_core psr_core_chk #(.OPND_W(OPND_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmp_valid  (cmp_valid),
  .cmp_src    (cmp_src),
  .cmp_dst    (cmp_dst),
  .alu_valid  (alu_valid),
  .alu_carry  (alu_carry),
  .ei_op      (ei_op),
  .di_op      (di_op),
  .trap_enter (trap_enter),
  .retire     (retire),
  .wr_en      (wr_en),
  .psr_q      (psr_q),
  .irq_accept (irq_accept),
  .trace_req  (trace_req)
);

// File: tb/tb_psr_core.sv
module tb_psr_core;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmp_valid = 1'b0;
  logic [W-1:0]  cmp_src = '0;
  logic [W-1:0]  cmp_dst = '0;
  logic          alu_valid = 1'b0;
  logic          alu_carry = 1'b0;
  logic          alu_ovf = 1'b0;
  logic          ei_op = 1'b0;
  logic          di_op = 1'b0;
  logic          trap_enter = 1'b0;
  logic          retire = 1'b0;
  logic          wr_en = 1'b0;
  logic [15:0]   wr_data = '0;
  logic [15:0]   psr_q;
  logic          irq_accept;
  logic          trace_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Behavioural expectation
  logic [15:0] exp_psr = '0;
  logic        exp_acc = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psr_core #(.OPND_W(W)) dut (
    .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .cmp_src(cmp_src),
    .cmp_dst(cmp_dst), .alu_valid(alu_valid), .alu_carry(alu_carry),
    .alu_ovf(alu_ovf), .ei_op(ei_op), .di_op(di_op), .trap_enter(trap_enter),
    .retire(retire), .wr_en(wr_en), .wr_data(wr_data), .psr_q(psr_q),
    .irq_accept(irq_accept), .trace_req(trace_req)
  );

  always @(posedge clk) begin
    logic [15:0] n;
    n = exp_psr;
    if (rst) begin
      n = '0;
    end else if (wr_en) begin
      n = wr_data & 16'h0EE7;
    end else begin
      if (cmp_valid) begin
        n[6] = (cmp_dst == cmp_src);
        n[2] = (int'(cmp_dst) < int'(cmp_src));
        n[7] = ($signed(cmp_dst) < $signed(cmp_src));
      end
      if (alu_valid) begin
        n[0] = alu_carry;
        n[5] = alu_ovf;
      end
      if (di_op) n[9] = 1'b0;
      else if (ei_op) n[9] = 1'b1;
      if (trap_enter) begin
        n[1] = 1'b0;
        n[10] = 1'b0;
      end else if (retire && exp_psr[1]) begin
        n[10] = 1'b1;
      end
    end
    exp_psr <= n;
    exp_acc <= n[9] & n[11];
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare every field group against the model; called away from the edge.
  task automatic check_all();
    chk("R2 compare flags", int'(psr_q & 16'h00C4), int'(exp_psr & 16'h00C4));
    chk("R3 carry/overflow", int'(psr_q & 16'h0021), int'(exp_psr & 16'h0021));
    chk("R4 local enable", int'(psr_q[9]), int'(exp_psr[9]));
    chk("R5 accept", int'(irq_accept), int'(exp_acc));
    chk("R6 trace/pending", int'(psr_q & 16'h0402), int'(exp_psr & 16'h0402));
    chk("R6 trace_req", int'(trace_req), int'(exp_psr[10]));
    chk("R8 dead bits", int'(psr_q & 16'hF118), 0);
    chk("R8 global enable", int'(psr_q[11]), int'(exp_psr[11]));
  endtask

  task automatic idle();
    cmp_valid = 0; alu_valid = 0; ei_op = 0; di_op = 0;
    trap_enter = 0; retire = 0; wr_en = 0;
  endtask

  // Hold the current inputs for one edge, then check and clear.
  task automatic step();
    @(negedge clk);
    check_all();
    idle();
  endtask

  task automatic do_cmp(input logic [W-1:0] d, input logic [W-1:0] s);
    cmp_valid = 1; cmp_dst = d; cmp_src = s;
    step();
  endtask

  task automatic do_wr(input logic [15:0] v);
    wr_en = 1; wr_data = v;
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1;
    @(negedge clk); @(negedge clk);
    // R1: reset state
    chk("R1 reset psr", int'(psr_q), 0);
    chk("R1 reset accept", int'(irq_accept), 0);
    chk("R1 reset trace_req", int'(trace_req), 0);
    rst = 0;
    step();

    // R2: operand patterns separating signed from unsigned order
    do_cmp(16'h1234, 16'h1234);
    chk("R2 equal", int'(psr_q[7:0] & 8'hC4), 32'h40);
    do_cmp(16'h0001, 16'hFFFF);
    chk("R2 unsigned-only less", int'(psr_q[7:0] & 8'hC4), 32'h04);
    do_cmp(16'hFFFF, 16'h0001);
    chk("R2 signed-only less", int'(psr_q[7:0] & 8'hC4), 32'h80);
    do_cmp(16'h0005, 16'h0009);
    chk("R2 both less", int'(psr_q[7:0] & 8'hC4), 32'h84);
    step();
    chk("R2 hold without compare", int'(psr_q[7:0] & 8'hC4), 32'h84);

    // R3
    alu_valid = 1; alu_carry = 1; alu_ovf = 0; step();
    chk("R3 carry", int'(psr_q & 16'h0021), 32'h1);
    alu_valid = 1; alu_carry = 0; alu_ovf = 1; step();
    chk("R3 overflow", int'(psr_q & 16'h0021), 32'h20);

    // R4 / R5
    ei_op = 1; step();
    chk("R4 ei sets", int'(psr_q[9]), 1);
    chk("R5 no global enable", int'(irq_accept), 0);
    do_wr(16'h0A00);
    chk("R5 both enables", int'(irq_accept), 1);
    ei_op = 1; di_op = 1; step();
    chk("R4 di wins", int'(psr_q[9]), 0);
    chk("R5 accept drops", int'(irq_accept), 0);

    // R8: reserved bits forced, write beats events
    wr_en = 1; wr_data = 16'hFFFF; trap_enter = 1; di_op = 1; step();
    chk("R8 masked write", int'(psr_q), 32'h0EE7);
    do_wr(16'h0000);

    // R6 / R9 / R7
    retire = 1; step(); retire = 1; step();
    chk("R9 no pending without trace", int'(trace_req), 0);
    do_wr(16'h0002);
    retire = 1; step();
    chk("R6 pending after retire", int'(trace_req), 1);
    retire = 1; step();
    chk("R9 still one pending", int'(psr_q & 16'h0402), 32'h0402);
    trap_enter = 1; retire = 1; step();
    chk("R7 trap clears both", int'(psr_q & 16'h0402), 0);
    retire = 1; step();
    chk("R7 no re-arm after trap", int'(trace_req), 0);

    // Random interaction
    for (int i = 0; i < 3000; i++) begin
      cmp_valid  = ($urandom % 3) == 0;
      cmp_src    = W'($urandom);
      cmp_dst    = ($urandom % 4 == 0) ? cmp_src : W'($urandom);
      alu_valid  = ($urandom % 3) == 0;
      alu_carry  = 1'($urandom);
      alu_ovf    = 1'($urandom);
      ei_op      = ($urandom % 5) == 0;
      di_op      = ($urandom % 6) == 0;
      trap_enter = ($urandom % 7) == 0;
      retire     = ($urandom % 2) == 0;
      wr_en      = ($urandom % 9) == 0;
      wr_data    = 16'($urandom);
      step();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule